// File: doc/BRIEF.md
# Two-Wire Slave Framing Engine

This block is the bit-level front end of a slave-only two-wire serial port. Both bus lines are sampled with a fast system clock. Each line passes through a two-flop synchroniser and a filter that needs two equal samples. From the filtered lines the block finds the start, repeated start and stop conditions. It shifts 8-bit words in and out most significant bit first, and it answers the ninth clock with an acknowledge. The block never drives the clock line. It pulls the data line low through an open-drain enable and otherwise releases it.

The 7-bit slave address has two parts. The upper five bits are a parameter. The lower two bits come from a configuration input that encodes one of four states, so four identical slaves can share one bus. The user logic receives single-cycle strobes:
- one for each start condition;
- one for each accepted stop condition;
- one for each byte written by the master;
- one each time a transmit byte is taken for a read.

Register storage and command decoding sit outside this block. The system clock must run at least 16 times faster than the bus clock.

Top module: `i2c_slave_framer`

## Requirements
- R1: A falling data line while the clock line is high is a start condition. The block pulses `start_o` and waits for an address byte.
- R2: A rising data line while the clock line is high is a stop condition, and it is accepted at any bit position, including mid-byte. The block pulses `stop_o`, drops the partial word without a `rx_valid`, releases SDA and returns to idle.
- R3: A repeated start, sent without an intervening stop, behaves exactly like a start. The bit count restarts and the next byte is decoded as an address.
- R4: A stop condition inside the same clock-high phase as the start just detected is ignored: no `stop_o` is raised and the block still expects an address. At least one clock-low phase must come between them.
- R5: The address byte matches when its upper seven bits equal `{ADDR_HI, addr_sel}`, with `addr_sel` in bits [1:0] of the address. On a match the block pulls SDA low for the ninth clock. On a mismatch SDA stays released and no strobe is raised until the next start or stop.
- R6: When the address byte's bit 0 is 0 (write), each following 8-bit word is shifted in MSB first. The word is presented on `rx_data` with a one-cycle `rx_valid`, and the block acknowledges it on the ninth clock.
- R7: When the address byte's bit 0 is 1 (read), the block loads `tx_data` and pulses `rd_stb` at the end of the address acknowledge and at the end of each acknowledged read word. It shifts the loaded byte out MSB first: an enable of 1 drives a 0 bit, and a released line is a 1 bit.
- R8: A high data line on the ninth clock of a read word is a NACK. It ends the read: SDA stays released and no further byte is loaded until the next start or stop.
- R9: Data is captured only on the rising clock edge. Changes of the data line while the clock is low do not alter the received word.
- R10: During reset, and after it until bus activity, all strobes are low and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Four-state address selection, forms address bits [1:0] |
| tx_data | input | 8 | Byte to send when the next read word is loaded |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| rx_data | output | 8 | Last word written by the master |
| rx_valid | output | 1 | One-cycle strobe, `rx_data` is new |
| rd_stb | output | 1 | One-cycle strobe, `tx_data` was taken |
| start_o | output | 1 | One-cycle strobe on start or repeated start |
| stop_o | output | 1 | One-cycle strobe on an accepted stop |

## Verification
A pad value sampled at one rising edge reaches the filtered line three edges later. The framing logic acts on it at the fourth edge after sampling, so every strobe and every change of `sda_oe` becomes visible right after that edge. The bench reference model keeps a history of sampled pad values and reasons from the entry four edges back. It updates on the rising edge and compares all outputs at the following falling edge, so each result is checked in the cycle it is due. Directed checks read the bus from the master side in the middle of each clock-high phase, well after the slave's data has settled.

// File: rtl/i2c_slave_framer.sv
module i2c_slave_framer #(
  parameter logic [4:0] ADDR_HI = 5'b10100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel,
  input  logic [7:0] tx_data,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rd_stb,
  output logic       start_o,
  output logic       stop_o
);

  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 2);
  localparam logic [CW-1:0] ACK_LO = CW'(BITS);
  localparam logic [CW-1:0] ACK_HI = CW'(BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_SKIP} st_t;

  logic [2:0]      scl_p, sda_p;
  logic            scl_f, sda_f, scl_q, sda_q;
  st_t             state;
  logic [CW-1:0]   cnt;
  logic [BITS-1:0] sr, txsr;
  logic            fresh, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1; sda_p <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      if (scl_p[1] == scl_p[2]) scl_f <= scl_p[1];
      if (sda_p[1] == sda_p[2]) sda_f <= sda_p[1];
      scl_q <= scl_f;
      sda_q <= sda_f;
    end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_ev = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  wire addr_hit = sr[BITS-1:1] == {ADDR_HI, addr_sel};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sr <= '0; txsr <= '0;
      fresh <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0; rx_data <= '0;
      rx_valid <= 1'b0; rd_stb <= 1'b0; start_o <= 1'b0; stop_o <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rd_stb   <= 1'b0;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
      if (start_ev) begin
        start_o <= 1'b1;
        state   <= S_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        fresh   <= 1'b1;
      end else if (stop_ev && !fresh) begin
        stop_o <= 1'b1;
        state  <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < ACK_LO) begin
            sr  <= {sr[BITS-2:0], sda_f};
            cnt <= cnt + 1'b1;
          end else if (cnt == ACK_LO) begin
            cnt <= ACK_HI;
            if (state == S_RD) mack <= ~sda_f;
          end
        end
        if (scl_fall) begin
          fresh <= 1'b0;
          if (cnt == ACK_LO) begin
            case (state)
              S_ADDR: if (addr_hit) sda_oe <= 1'b1; else state <= S_SKIP;
              S_WR: begin
                rx_data  <= sr;
                rx_valid <= 1'b1;
                sda_oe   <= 1'b1;
              end
              S_RD:    sda_oe <= 1'b0;
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == ACK_HI) begin
            cnt <= '0;
            if ((state == S_ADDR && sr[0]) || (state == S_RD && mack)) begin
              state  <= S_RD;
              txsr   <= tx_data;
              sda_oe <= ~tx_data[BITS-1];
              rd_stb <= 1'b1;
            end else begin
              sda_oe <= 1'b0;
              if (state == S_ADDR) state <= S_WR;
              else if (state == S_RD) state <= S_SKIP;
            end
          end else if (state == S_RD && cnt != '0) begin
            txsr   <= {txsr[BITS-2:0], 1'b0};
            sda_oe <= ~txsr[BITS-2];
          end
        end
      end
    end

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o)); // R1
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (state == S_ADDR && cnt == '0 && !sda_oe)); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (state == S_IDLE && !sda_oe)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe); // R2
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> (!sda_oe && !rx_valid && !rd_stb)); // R5
  AST_RXV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (state == S_WR && sda_oe)); // R6
  AST_RDSTB_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (state == S_RD && cnt == '0)); // R7
  AST_NACK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && $past(state) == S_RD && scl_fall && cnt == ACK_HI && !mack)
      |=> (state == S_SKIP && !sda_oe)); // R8

endmodule

// File: tb/i2c_slave_framer_bench.sv
module i2c_slave_framer_bench;
  localparam logic [4:0] AHI = 5'b10100;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic [7:0] tx_data;
  logic sda_oe, rx_valid, rd_stb, start_o, stop_o;
  logic [7:0] rx_data;
  wire sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_slave_framer #(.ADDR_HI(AHI)) u_i2c_slave_framer (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(addr_sel), .tx_data(tx_data), .sda_oe(sda_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rd_stb(rd_stb),
    .start_o(start_o), .stop_o(stop_o));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_stop = 0, n_rxv = 0, n_rd = 0;
  logic [7:0] last_rx = '0;
  bit done = 0;

  function automatic logic [7:0] txval(input int i);
    return 8'(8'hA5 ^ (i * 37));
  endfunction
  assign tx_data = txval(n_rd);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference model: acts on pad samples four edges old
  logic [1:0] pq[$] = '{2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11};
  int ms = 0, mcnt = 0;
  logic [7:0] msr = '0, mtx = '0, e_rxd = '0;
  bit mfresh = 0, mack = 0;
  bit e_start = 0, e_stop = 0, e_rxv = 0, e_rd = 0, e_oe = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq = '{2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11};
      ms = 0; mcnt = 0; mfresh = 0; mack = 0;
      e_start = 0; e_stop = 0; e_rxv = 0; e_rd = 0; e_oe = 0;
    end else begin
      bit fs, ps, fd, pd;
      pq.push_front({scl_m, sda_bus});
      void'(pq.pop_back());
      fs = pq[4][1]; ps = pq[5][1]; fd = pq[4][0]; pd = pq[5][0];
      e_start = 0; e_stop = 0; e_rxv = 0; e_rd = 0;
      if (fs && ps && pd && !fd) begin
        e_start = 1; ms = 1; mcnt = 0; e_oe = 0; mfresh = 1;
      end else if (fs && ps && !pd && fd && !mfresh) begin
        e_stop = 1; ms = 0; mcnt = 0; e_oe = 0;
      end else if (ms != 0) begin
        if (fs && !ps) begin
          if (mcnt < 8) begin msr = {msr[6:0], fd}; mcnt++; end
          else if (mcnt == 8) begin mcnt = 9; if (ms == 3) mack = !fd; end
        end
        if (!fs && ps) begin
          mfresh = 0;
          if (mcnt == 8) begin
            if (ms == 1) begin
              if (msr[7:1] == {AHI, addr_sel}) e_oe = 1; else ms = 4;
            end else if (ms == 2) begin
              e_rxd = msr; e_rxv = 1; e_oe = 1;
            end else e_oe = 0;
          end else if (mcnt == 9) begin
            mcnt = 0;
            if ((ms == 1 && msr[0]) || (ms == 3 && mack)) begin
              ms = 3; mtx = tx_data; e_oe = !mtx[7]; e_rd = 1;
            end else begin
              e_oe = 0;
              if (ms == 1) ms = 2; else if (ms == 3) ms = 4;
            end
          end else if (ms == 3 && mcnt != 0) begin
            e_oe = !mtx[8 - mcnt - 1];
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", start_o, e_start, "start strobe");
      chk("R2", stop_o, e_stop, "stop strobe");
      chk("R6", rx_valid, e_rxv, "rx_valid");
      if (e_rxv) chk("R6", rx_data, e_rxd, "rx_data");
      chk("R7", rd_stb, e_rd, "rd_stb");
      chk("R5", sda_oe, e_oe, "sda_oe");
      if (start_o) n_start++;
      if (stop_o) n_stop++;
      if (rx_valid) begin n_rxv++; last_rx = rx_data; end
      if (rd_stb) n_rd++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_start;
    if (!scl_m) begin sda_m = 1; wq(Q); scl_m = 1; wq(Q); end
    sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic m_stop;
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic m_bit(input bit b, input bit wig, output bit got);
    if (wig) begin
      sda_m = ~b; wq(2); sda_m = b; wq(2); sda_m = ~b; wq(2);
    end
    sda_m = b; wq(Q); scl_m = 1; wq(Q / 2); got = sda_bus; wq(Q / 2);
    scl_m = 0; wq(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] v, input bit wig, output bit acked);
    bit g;
    for (int i = 7; i >= 0; i--) m_bit(v[i], wig, g);
    m_bit(1'b1, 1'b0, g);
    acked = !g;
  endtask

  task automatic m_rbyte(input bit ack, output logic [7:0] v);
    bit g;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, 1'b0, g); v[i] = g; end
    m_bit(!ack, 1'b0, g);
  endtask

  initial begin
    bit a;
    logic [7:0] rv;
    int s0, p0, r0, d0;
    wq(10);
    chk("R10", {sda_oe, rx_valid, rd_stb, start_o, stop_o}, 5'b0, "outputs in reset");
    rst_n = 1; wq(20);
    chk("R10", {sda_oe, rx_valid, rd_stb, start_o, stop_o}, 5'b0, "outputs after reset");

    addr_sel = 2'd2;
    m_start(); m_wbyte({AHI, 2'd2, 1'b0}, 0, a);
    chk("R5", a, 1, "address ack");
    m_wbyte(8'h3C, 0, a); chk("R6", a, 1, "data ack");
    chk("R6", last_rx, 8'h3C, "first word");
    m_wbyte(8'hC3, 0, a); chk("R6", last_rx, 8'hC3, "second word");
    m_stop(); wq(Q);
    chk("R1", n_start, 1, "start count");
    chk("R2", n_stop, 1, "stop count");

    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      m_start(); m_wbyte({AHI, 2'(s), 1'b0}, 0, a);
      chk("R5", a, 1, "ack for each address state");
      m_wbyte(8'(s * 17 + 1), 0, a);
      chk("R6", last_rx, 8'(s * 17 + 1), "word per address state");
      m_stop(); wq(Q);
    end

    addr_sel = 2'd1; r0 = n_rxv;
    m_start(); m_wbyte({AHI, 2'd2, 1'b0}, 0, a);
    chk("R5", a, 0, "mismatch not acked");
    m_wbyte(8'h77, 0, a);
    chk("R5", a, 0, "data after mismatch not acked");
    chk("R5", n_rxv, r0, "no word after mismatch");
    m_stop(); wq(Q);

    d0 = n_rd;
    m_start(); m_wbyte({AHI, 2'd1, 1'b1}, 0, a);
    chk("R7", a, 1, "read address ack");
    m_rbyte(1, rv); chk("R7", rv, txval(d0), "read word 0");
    m_rbyte(1, rv); chk("R7", rv, txval(d0 + 1), "read word 1");
    m_rbyte(0, rv); chk("R7", rv, txval(d0 + 2), "read word 2");
    chk("R7", n_rd, d0 + 3, "loads in read");
    m_rbyte(0, rv);
    chk("R8", rv, 8'hFF, "released after NACK");
    chk("R8", n_rd, d0 + 3, "no load after NACK");
    m_stop(); wq(Q);

    s0 = n_start; d0 = n_rd;
    m_start(); m_wbyte({AHI, 2'd1, 1'b0}, 0, a);
    m_wbyte(8'h11, 0, a); chk("R6", last_rx, 8'h11, "word before restart");
    m_start(); m_wbyte({AHI, 2'd1, 1'b1}, 0, a);
    chk("R3", a, 1, "address after repeated start acked");
    m_rbyte(0, rv); chk("R3", rv, txval(d0), "read after repeated start");
    m_stop(); wq(Q);
    chk("R3", n_start, s0 + 2, "repeated start strobe");

    p0 = n_stop; s0 = n_start;
    sda_m = 0; wq(Q); sda_m = 1; wq(Q); scl_m = 0; wq(Q);
    m_wbyte({AHI, 2'd1, 1'b0}, 0, a);
    chk("R4", a, 1, "address still expected after early stop");
    chk("R4", n_stop, p0, "early stop ignored");
    m_wbyte(8'h5A, 0, a); chk("R4", last_rx, 8'h5A, "word after early stop");
    m_stop(); wq(Q);
    chk("R4", n_stop, p0 + 1, "real stop counted");
    chk("R1", n_start, s0 + 1, "start before early stop");

    p0 = n_stop; r0 = n_rxv;
    m_start(); m_wbyte({AHI, 2'd1, 1'b0}, 0, a);
    for (int i = 0; i < 4; i++) m_bit(i[0], 0, a);
    m_stop(); wq(Q);
    chk("R2", n_stop, p0 + 1, "mid-word stop");
    chk("R2", n_rxv, r0, "partial word dropped");
    chk("R2", sda_oe, 0, "released after stop");

    m_start(); m_wbyte({AHI, 2'd1, 1'b0}, 0, a);
    m_wbyte(8'h96, 1, a);
    chk("R9", a, 1, "word with low-phase noise acked");
    chk("R9", last_rx, 8'h96, "low-phase changes ignored");
    m_stop(); wq(Q);

    finish_run();
  end
endmodule